// File: doc/BRIEF.md
# Global-history correlating branch direction predictor

This block guesses whether a conditional branch will be taken. It keeps a short register of the most recent resolved branch outcomes. It also keeps one table of 2-bit saturating counters for every value that register can hold. A lookup takes the branch address and answers in the same cycle. The history register picks the table, and low address bits pick the counter inside it.

When the branch later resolves, the pipeline returns three things: the branch address, the real outcome, and the history value that the lookup port reported when the guess was made. The block then trains only the counter that made the guess. It also shifts the real outcome into the history register. With the default parameters there are two history bits, four tables, and sixteen counters per table, indexed by address bits [5:2].

Top module: `corr_predictor`

## Requirements
- R1: After reset, `lk_hist` is 00 and every counter holds 1, so every lookup predicts not taken (`lk_taken`=0).
- R2: `lk_taken` is 1 exactly when the selected counter is 2 or 3. It is combinational from `lk_pc` and the current state, with no cycle of delay.
- R3: The counter used by a lookup is entry `lk_pc[5:2]` of the table numbered by the current `lk_hist`. Address bits [1:0] and bits above 5 have no effect on the prediction.
- R4: A resolve with `rs_taken`=1 increments the addressed counter, and the counter stays at 3 once it is there.
- R5: A resolve with `rs_taken`=0 decrements the addressed counter, and the counter stays at 0 once it is there. As a result, a strongly held prediction flips only after two opposite outcomes in a row.
- R6: A resolve changes only entry `rs_pc[5:2]` of table `rs_hist`. All other entries, including the same entry in the other three tables, keep their values.
- R7: Each resolve shifts the history left by one and places `rs_taken` in bit 0 (1 = taken). Bit 1 therefore always holds the older of the two outcomes.
- R8: A cycle without `rs_valid` changes neither the history nor any counter.
- R9: Training uses the table given by `rs_hist`, even when it differs from the current `lk_hist`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PCW | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HISTW | Current global history; the pipeline carries it to resolve |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PCW | Address of the resolving branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| rs_hist | input | HISTW | History value captured at prediction time |

## Verification
If a counter holds a wrong value, the error shows up on `lk_taken` in the same cycle as the first lookup that selects that entry. That lookup must use the matching address bits and the matching history, so the bench first steers the history to each table in turn before it reads a counter. If the history register is wrong, the error shows up on `lk_hist` one cycle after the faulty resolve. A training write that lands in the wrong table shows up only when the history is later steered to the damaged table. For that reason, the bench reads the same entry back through all four tables.

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int PCW    = 32,
  parameter int IDXW   = 4,
  parameter int HISTW  = 2,
  parameter int PC_LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PCW-1:0]   lk_pc,
  output logic             lk_taken,
  output logic [HISTW-1:0] lk_hist,
  input  logic             rs_valid,
  input  logic [PCW-1:0]   rs_pc,
  input  logic             rs_taken,
  input  logic [HISTW-1:0] rs_hist
);
  localparam int SELW  = HISTW + IDXW;
  localparam int SLOTS = 1 << SELW;

  logic [HISTW-1:0]       ghr;
  logic [SLOTS-1:0][1:0]  cnt;
  logic [SELW-1:0]        lk_sel, rs_sel;
  logic [1:0]             cur;

  assign lk_sel   = {ghr, lk_pc[PC_LSB +: IDXW]};
  assign rs_sel   = {rs_hist, rs_pc[PC_LSB +: IDXW]};
  assign cur      = cnt[rs_sel];
  assign lk_taken = cnt[lk_sel][1];
  assign lk_hist  = ghr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr <= '0;
      for (int i = 0; i < SLOTS; i++) cnt[i] <= 2'd1;
    end else if (rs_valid) begin
      ghr <= {ghr[HISTW-2:0], rs_taken};
      if (rs_taken && cur != 2'd3)
        cnt[rs_sel] <= cur + 2'd1;
      else if (!rs_taken && cur != 2'd0)
        cnt[rs_sel] <= cur - 2'd1;
    end
  end
endmodule

// File: rtl/corr_predictor_chk.sv
module corr_predictor_chk #(
  parameter int PCW    = 32,
  parameter int IDXW   = 4,
  parameter int HISTW  = 2,
  parameter int PC_LSB = 2
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [PCW-1:0]                        lk_pc,
  input logic                                  lk_taken,
  input logic [HISTW-1:0]                      lk_hist,
  input logic                                  rs_valid,
  input logic [PCW-1:0]                        rs_pc,
  input logic                                  rs_taken,
  input logic [HISTW-1:0]                      rs_hist,
  input logic [(1<<(HISTW+IDXW))-1:0][1:0]     cnt
);
  localparam int SELW = HISTW + IDXW;
  logic [SELW-1:0] rsel, lsel;
  assign rsel = {rs_hist, rs_pc[PC_LSB +: IDXW]};
  assign lsel = {lk_hist, lk_pc[PC_LSB +: IDXW]};

  a_r2_pred_from_counter: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken == cnt[lsel][1]);

  a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> lk_hist == {$past(lk_hist[HISTW-2:0]), $past(rs_taken)});

  a_r8_idle_hist: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(lk_hist));

  a_r8_idle_tables: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(cnt));

  a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_taken |=>
      cnt[$past(rsel)] == (($past(cnt[rsel]) == 2'd3) ? 2'd3 : $past(cnt[rsel]) + 2'd1));

  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_taken |=>
      cnt[$past(rsel)] == (($past(cnt[rsel]) == 2'd0) ? 2'd0 : $past(cnt[rsel]) - 2'd1));
endmodule

bind corr_predictor corr_predictor_chk #(
  .PCW(PCW), .IDXW(IDXW), .HISTW(HISTW), .PC_LSB(PC_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
  .lk_hist(lk_hist), .rs_valid(rs_valid), .rs_pc(rs_pc),
  .rs_taken(rs_taken), .rs_hist(rs_hist), .cnt(cnt)
);

// File: tb/corr_predictor_test.sv
`timescale 1ns/1ps
module corr_predictor_test;
  logic        clk = 0, rst_n = 0;
  logic [31:0] lk_pc = 0, rs_pc = 0;
  logic        lk_taken, rs_valid = 0, rs_taken = 0;
  logic [1:0]  lk_hist, rs_hist = 0;
  int errors = 0, checks = 0;
  int m [4][16];
  int ghm = 0;

  always #2.5 clk = ~clk;

  corr_predictor uut (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_hist(rs_hist));

  function automatic logic [31:0] mkpc(int idx, int hi, int lo);
    return (32'(hi) << 6) | (32'(idx) << 2) | 32'(lo);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic resolve(int idx, int h, bit t, int hi = 0);
    @(negedge clk);
    rs_valid = 1; rs_pc = mkpc(idx, hi, 1); rs_hist = 2'(h); rs_taken = t;
    @(negedge clk);
    rs_valid = 0;
    if (t && m[h][idx] < 3) m[h][idx]++;
    else if (!t && m[h][idx] > 0) m[h][idx]--;
    ghm = ((ghm << 1) | int'(t)) & 3;
    check("R7", "history after resolve", int'(lk_hist), ghm);
  endtask

  task automatic steer(int h);
    resolve(15, ghm, bit'((h >> 1) & 1));
    resolve(15, ghm, bit'(h & 1));
  endtask

  task automatic pred(string req, int idx, int hi = 0, int lo = 0);
    lk_pc = mkpc(idx, hi, lo);
    #1;
    check(req, "prediction", int'(lk_taken), int'(m[ghm][idx] >= 2));
  endtask

  task automatic t_reset();
    check("R1", "history at reset", int'(lk_hist), 0);
    for (int i = 0; i < 16; i += 5) begin
      lk_pc = mkpc(i, 0, 0); #1;
      check("R1", "prediction at reset", int'(lk_taken), 0);
    end
  endtask

  task automatic t_train_up_down();
    resolve(3, 0, 1); resolve(3, 0, 1);
    steer(0); pred("R2", 3);
    check("R4", "entry 3 table 0 taken", int'(lk_taken), 1);
    resolve(3, 0, 1); resolve(3, 0, 1); resolve(3, 0, 1);
    resolve(3, 0, 0);
    steer(0); pred("R5", 3);
    check("R5", "one miss keeps taken", int'(lk_taken), 1);
    resolve(3, 0, 0);
    steer(0); pred("R5", 3);
    check("R5", "second miss flips", int'(lk_taken), 0);
  endtask

  task automatic t_isolation();
    resolve(7, 0, 1); resolve(7, 0, 1);
    for (int h = 1; h < 4; h++) begin
      steer(h); pred("R6", 7);
      check("R6", "other table untouched", int'(lk_taken), 0);
    end
    steer(0); pred("R6", 8);
    check("R6", "neighbour entry untouched", int'(lk_taken), 0);
    pred("R6", 7);
  endtask

  task automatic t_index_bits();
    steer(0);
    pred("R3", 7, 0, 0);
    pred("R3", 7, 12345, 3);
    check("R3", "upper and low bits ignored", int'(lk_taken), 1);
  endtask

  task automatic t_floor();
    for (int k = 0; k < 4; k++) resolve(9, 1, 0);
    resolve(9, 1, 1);
    steer(1); pred("R5", 9);
    check("R5", "floor then one taken", int'(lk_taken), 0);
    resolve(9, 1, 1);
    steer(1); pred("R4", 9);
  endtask

  task automatic t_rs_hist();
    steer(0);
    resolve(5, 2, 1); resolve(5, 2, 1);
    steer(2); pred("R9", 5);
    check("R9", "trained table from rs_hist", int'(lk_taken), 1);
    steer(0); pred("R9", 5);
  endtask

  task automatic t_idle();
    int h0;
    h0 = int'(lk_hist);
    repeat (5) @(negedge clk);
    check("R8", "history stable when idle", int'(lk_hist), h0);
    pred("R8", 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int h = 0; h < 4; h++) for (int i = 0; i < 16; i++) m[h][i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_train_up_down();
    t_isolation();
    t_index_bits();
    t_floor();
    t_rs_hist();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule